// File: doc/BRIEF.md
# Extended Transfer Bus-Sizing Sequencer

This block sits on the master side of a 64-bit byte-laned data bus. It takes one request for an odd-length extended transfer of 5, 6 or 7 bytes and plays it out as one or more bus beats. The slave port it addresses may be 64, 32, 16 or 8 bits wide. Each beat is announced by a one-cycle start strobe and closed by an acknowledge from the slave. During the beat the block presents the byte count still to be moved and the low three address bits.

On writes, the block places each operand byte on its natural lane. It also copies the leading bytes onto the low lanes where a narrower port expects them. On reads, it takes each beat's bytes from the lanes that the port width implies and builds them into one doubleword image. When the last beat is acknowledged, it returns the result right-justified. Illegal size and offset pairs are rejected with a one-cycle error pulse, and so is any request made while extended transfers are disabled. A rejected request produces no bus activity.

Byte position p (0 to 7) is the low address offset within the doubleword. Lane L is bus bits [8L+7:8L]. In an operand vector such as `req_wdata`, byte p sits at bits [8p+7:8p]. `port_sel` encodes the width as 0 = 64 bits, 1 = 32, 2 = 16 and 3 = 8. W below is the port width in bytes.

Top module: `ext_xfer_seq`

## Requirements
- R1: A request made while `ext_en` is 1 is accepted only for size code 0101 (5 bytes) at offset 000 or 011, code 0110 (6 bytes) at 000 or 010, or code 0111 (7 bytes) at 000 or 001. Every other size code and offset is rejected, including the 16- and 24-byte codes. A rejection gives `err` high for exactly the cycle after the request, and no `bus_start` follows.
- R2: While `ext_en` is 0, every request is rejected as in R1, including the six legal pairs.
- R3: With a 64-bit port, an accepted transfer runs as a single beat. That beat shows `bus_size` equal to the request's size code and `bus_addr` equal to its offset.
- R4: With a narrower port, each beat moves min(remaining, W − (offset mod W)) bytes. After each acknowledge, `bus_addr` advances by the bytes moved and `bus_size` shows the new remaining count. Beats continue until the count reaches zero.
- R5: On a write beat with offset a and remaining count r, take each aligned chunk of width 8, 4, 2 and 1 byte that contains a. Every byte p in [a, a+r) that lies inside such a chunk appears on lane p mod chunk width. Lanes that none of these chunks cover are driven to zero. At 64-bit width this yields, for example, lanes 0..3 = bytes 3,3,0,3 for 5 bytes at 011.
- R6: On a read beat, byte p of that beat is taken from lane p mod W, and all other lanes are ignored.
- R7: One cycle after the final acknowledge, `xfer_done` pulses for one cycle. On reads, `rd_valid` pulses with it. `rd_data` byte i then holds the byte read at position offset+i for i below the length, and the bytes at and above the length are zero.
- R8: `bus_start` is high for exactly one cycle per beat. `bus_addr` and `bus_size` hold steady until the beat's acknowledge, and an acknowledge in the start cycle itself is not counted.
- R9: `req_ready` is high only while idle. A request presented during a transfer has no effect: it raises no `err` and does not alter the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Extended transfers permitted when 1 |
| port_sel | input | 2 | Slave port width code, sampled on acceptance |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 4 | Transfer size code |
| req_addr | input | 3 | Low address offset |
| req_wdata | input | 64 | Write operand, byte p at position p |
| req_ready | output | 1 | Idle and able to take a request |
| err | output | 1 | One-cycle rejection pulse |
| bus_start | output | 1 | Start of beat |
| bus_write | output | 1 | Direction of the current transfer |
| bus_addr | output | 3 | Low address of the current beat |
| bus_size | output | 4 | Remaining byte count of the current beat |
| bus_wdata | output | 64 | Steered write lanes |
| bus_ack | input | 1 | Beat acknowledge from the slave |
| bus_rdata | input | 64 | Read lanes from the slave |
| xfer_done | output | 1 | Transfer complete pulse |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 56 | Right-justified read result |

## Verification
The hardest case is the last beat of a narrow-port transfer that starts at an unaligned offset. Reaching it takes the right port width, offset and size together, plus the correct running count across up to seven acknowledges. The stimulus therefore sweeps every port width against all six legal size-offset pairs in both directions, answering each beat after one to three cycles of delay. The slave model fills the lanes it should not be read from with marker bytes, so that a wrong lane choice in a late beat shows up in the assembled result. A stray illegal request is injected in the middle of some transfers to show that it is ignored.

// File: rtl/ext_xfer_pkg.sv
package ext_xfer_pkg;

  typedef enum logic [1:0] {
    PW64 = 2'd0,
    PW32 = 2'd1,
    PW16 = 2'd2,
    PW8  = 2'd3
  } port_w_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_st_e;

  // Width of the slave port in bytes for a 64-bit lane set.
  function automatic int port_bytes(input port_w_e pw);
    case (pw)
      PW64:    return 8;
      PW32:    return 4;
      PW16:    return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/ext_legal_chk.sv
module ext_legal_chk #(
  parameter int CNT_W = 4,
  parameter int OFF_W = 3
) (
  input  logic             ext_en,
  input  logic [CNT_W-1:0] size_code,
  input  logic [OFF_W-1:0] offset,
  output logic             legal
);
  logic pair_ok;

  always_comb begin
    case (int'(size_code))
      5:       pair_ok = (int'(offset) == 0) || (int'(offset) == 3);
      6:       pair_ok = (int'(offset) == 0) || (int'(offset) == 2);
      7:       pair_ok = (int'(offset) == 0) || (int'(offset) == 1);
      default: pair_ok = 1'b0;
    endcase
    legal = ext_en & pair_ok;
  end
endmodule

// File: rtl/ext_beat_calc.sv
module ext_beat_calc
  import ext_xfer_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  port_w_e          pw,
  input  logic [CNT_W-1:0] cur_off,
  input  logic [CNT_W-1:0] remain,
  output logic [CNT_W-1:0] moved,
  output logic             last
);
  always_comb begin
    int w;
    int room;
    int mv;
    w    = port_bytes(pw);
    room = w - (int'(cur_off) % w);
    mv   = (int'(remain) < room) ? int'(remain) : room;
    moved = CNT_W'(mv);
    last  = (mv == int'(remain));
  end
endmodule

// File: rtl/ext_wr_steer.sv
module ext_wr_steer #(
  parameter int LANES = 8,
  parameter int OFF_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [OFF_W-1:0]   cur_off,
  input  logic [CNT_W-1:0]   remain,
  input  logic [8*LANES-1:0] operand,
  output logic [8*LANES-1:0] lanes
);
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    always_comb begin
      logic hit;
      int   sel;
      int   w;
      int   p;
      hit = 1'b0;
      sel = 0;
      // Widest chunk first; narrower chunks fill the low lanes.
      for (int k = 0; k <= OFF_W; k++) begin
        w = LANES >> k;
        p = (int'(cur_off) & ~(w - 1)) + L;
        if (!hit && (L < w) && (p >= int'(cur_off)) &&
            (p < int'(cur_off) + int'(remain))) begin
          hit = 1'b1;
          sel = p;
        end
      end
      lanes[8*L +: 8] = hit ? operand[8*sel +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/ext_rd_gather.sv
module ext_rd_gather
  import ext_xfer_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 4
) (
  input  port_w_e            pw,
  input  logic [CNT_W-1:0]   cur_off,
  input  logic [CNT_W-1:0]   moved,
  input  logic [8*LANES-1:0] lanes,
  output logic [LANES-1:0]   byte_en,
  output logic [8*LANES-1:0] bytes
);
  for (genvar P = 0; P < LANES; P++) begin : g_pos
    always_comb begin
      int w;
      int ln;
      w  = port_bytes(pw);
      ln = P & (w - 1);
      byte_en[P]      = (P >= int'(cur_off)) && (P < int'(cur_off) + int'(moved));
      bytes[8*P +: 8] = lanes[8*ln +: 8];
    end
  end
endmodule

// File: rtl/ext_xfer_seq.sv
module ext_xfer_seq
  import ext_xfer_pkg::*;
#(
  parameter  int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = OFF_W + 1,
  localparam int DW    = 8 * LANES,
  localparam int RW    = 8 * (LANES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_en,
  input  logic [1:0]       port_sel,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CNT_W-1:0] req_size,
  input  logic [OFF_W-1:0] req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             err,
  output logic             bus_start,
  output logic             bus_write,
  output logic [OFF_W-1:0] bus_addr,
  output logic [CNT_W-1:0] bus_size,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_ack,
  input  logic [DW-1:0]    bus_rdata,
  output logic             xfer_done,
  output logic             rd_valid,
  output logic [RW-1:0]    rd_data
);

  seq_st_e          st, st_n;
  logic [CNT_W-1:0] cur_off, off_n;
  logic [CNT_W-1:0] remain, rem_n;
  logic [OFF_W-1:0] base_off;
  logic [CNT_W-1:0] tot_len;
  logic             is_wr;
  port_w_e          pw_q;
  logic [DW-1:0]    wbuf;
  logic [DW-1:0]    cap, cap_mrg;
  logic             ld_en, cap_we;
  logic             err_n, done_n, rdv_n;
  logic             req_ok;
  logic [CNT_W-1:0] beat_moved;
  logic             beat_last;
  logic [LANES-1:0] g_en;
  logic [DW-1:0]    g_bytes;
  logic [DW-1:0]    steer;

  ext_legal_chk #(.CNT_W(CNT_W), .OFF_W(OFF_W)) i_legal (
    .ext_en    (ext_en),
    .size_code (req_size),
    .offset    (req_addr),
    .legal     (req_ok)
  );

  ext_beat_calc #(.CNT_W(CNT_W)) i_beat (
    .pw      (pw_q),
    .cur_off (cur_off),
    .remain  (remain),
    .moved   (beat_moved),
    .last    (beat_last)
  );

  ext_wr_steer #(.LANES(LANES), .OFF_W(OFF_W), .CNT_W(CNT_W)) i_steer (
    .cur_off (cur_off[OFF_W-1:0]),
    .remain  (remain),
    .operand (wbuf),
    .lanes   (steer)
  );

  ext_rd_gather #(.LANES(LANES), .CNT_W(CNT_W)) i_gather (
    .pw      (pw_q),
    .cur_off (cur_off),
    .moved   (beat_moved),
    .lanes   (bus_rdata),
    .byte_en (g_en),
    .bytes   (g_bytes)
  );

  // Next-state logic
  always_comb begin
    st_n   = st;
    off_n  = cur_off;
    rem_n  = remain;
    ld_en  = 1'b0;
    cap_we = 1'b0;
    err_n  = 1'b0;
    done_n = 1'b0;
    rdv_n  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_ok) begin
            st_n  = ST_ISSUE;
            ld_en = 1'b1;
            off_n = {1'b0, req_addr};
            rem_n = req_size;
          end else begin
            err_n = 1'b1;
          end
        end
      end
      ST_ISSUE: st_n = ST_WAIT;
      ST_WAIT: begin
        if (bus_ack) begin
          cap_we = 1'b1;
          off_n  = cur_off + beat_moved;
          rem_n  = remain - beat_moved;
          if (beat_last) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
            rdv_n  = ~is_wr;
          end else begin
            st_n = ST_ISSUE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    for (int p = 0; p < LANES; p++) begin
      cap_mrg[8*p +: 8] = g_en[p] ? g_bytes[8*p +: 8] : cap[8*p +: 8];
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_off   <= '0;
      remain    <= '0;
      err       <= 1'b0;
      xfer_done <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      st        <= st_n;
      cur_off   <= off_n;
      remain    <= rem_n;
      err       <= err_n;
      xfer_done <= done_n;
      rd_valid  <= rdv_n;
    end
  end

  // Request holding registers, loaded on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_off <= '0;
      tot_len  <= '0;
      is_wr    <= 1'b0;
      pw_q     <= PW64;
      wbuf     <= '0;
    end else if (ld_en) begin
      base_off <= req_addr;
      tot_len  <= req_size;
      is_wr    <= req_write;
      pw_q     <= port_w_e'(port_sel);
      wbuf     <= req_wdata;
    end
  end

  // Read capture image
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
    end else if (ld_en) begin
      cap <= '0;
    end else if (cap_we) begin
      cap <= cap_mrg;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES - 1; i++) begin
      int idx;
      idx = int'(base_off) + i;
      if ((i < int'(tot_len)) && (idx < LANES)) rd_data[8*i +: 8] = cap[8*idx +: 8];
      else                                      rd_data[8*i +: 8] = 8'h00;
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign bus_start = (st == ST_ISSUE);
  assign bus_write = is_wr;
  assign bus_addr  = cur_off[OFF_W-1:0];
  assign bus_size  = remain;
  assign bus_wdata = is_wr ? steer : '0;

endmodule

// File: rtl/ext_xfer_seq_chk.sv
module ext_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       err,
  input logic       bus_start,
  input logic [2:0] bus_addr,
  input logic [3:0] bus_size,
  input logic       xfer_done,
  input logic       rd_valid
);
  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!bus_start && req_ready));                                          // R1
  AST_SIZE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> ((bus_size != 4'd0) && (bus_size <= 4'd7)));                   // R4
  AST_BEAT_IN_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> (({2'b00, bus_addr} + {1'b0, bus_size}) <= 5'd8));             // R4
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);                                                   // R8
  AST_BEAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !bus_start) |-> ($stable(bus_addr) && $stable(bus_size)));    // R8
  AST_RDV_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> xfer_done);                                                     // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);                                                   // R7
  AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !err);                                                        // R9
endmodule

bind ext_xfer_seq ext_xfer_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .err       (err),
  .bus_start (bus_start),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .xfer_done (xfer_done),
  .rd_valid  (rd_valid)
);

// File: tb/test_ext_xfer_seq.sv
module test_ext_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        ext_en;
  logic [1:0]  port_sel;
  logic        req_valid;
  logic        req_write;
  logic [3:0]  req_size;
  logic [2:0]  req_addr;
  logic [63:0] req_wdata;
  logic        req_ready;
  logic        err;
  logic        bus_start;
  logic        bus_write;
  logic [2:0]  bus_addr;
  logic [3:0]  bus_size;
  logic [63:0] bus_wdata;
  logic        bus_ack;
  logic [63:0] bus_rdata;
  logic        xfer_done;
  logic        rd_valid;
  logic [55:0] rd_data;

  int n_checks;
  int n_errors;
  int cyc;

  ext_xfer_seq i_ext_xfer_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_en    (ext_en),
    .port_sel  (port_sel),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .err       (err),
    .bus_start (bus_start),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .xfer_done (xfer_done),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit is_legal(input int n, input int a);
    return (n == 5 && (a == 0 || a == 3)) || (n == 6 && (a == 0 || a == 2)) ||
           (n == 7 && (a == 0 || a == 1));
  endfunction

  function automatic logic [7:0] wbyte(input int seed, input int p);
    return 8'(seed * 13 + p * 29 + 7);
  endfunction

  function automatic logic [7:0] mbyte(input int seed, input int p);
    return 8'(seed * 7 + p * 31 + 3);
  endfunction

  task automatic run_bad(input bit en, input int n, input int a, input string tag);
    @(negedge clk);
    ext_en = en; req_valid = 1'b1; req_write = 1'b1;
    req_size = 4'(n); req_addr = 3'(a); req_wdata = 64'h1122334455667788;
    @(negedge clk);
    req_valid = 1'b0;
    check(err && !bus_start && req_ready, tag, {62'b0, err, bus_start}, 64'h2);
    @(negedge clk);
    check(!err && !bus_start, tag, {62'b0, err, bus_start}, 64'h0);
    ext_en = 1'b1;
  endtask

  task automatic run_xfer(input int pw, input bit wr, input int n, input int a, input int seed);
    int    w;
    int    e_off;
    int    e_rem;
    int    beats;
    int    e_beats;
    int    waitc;
    bit    done_seen;
    bit    err_seen;
    bit    junk;
    bit    ok;
    logic [63:0] exp_l;
    logic [55:0] exp_rd;
    string tg;
    w = 8 >> pw;
    junk = (seed % 4) == 1;
    tg = (pw == 0) ? "R3" : "R4";
    // Expected beat count from the splitting rule
    e_beats = 0; e_off = a; e_rem = n;
    while (e_rem > 0) begin
      int mv;
      mv = w - (e_off % w);
      if (mv > e_rem) mv = e_rem;
      e_off += mv; e_rem -= mv; e_beats++;
    end
    @(negedge clk);
    port_sel = 2'(pw); req_valid = 1'b1; req_write = wr;
    req_size = 4'(n); req_addr = 3'(a);
    for (int p = 0; p < 8; p++) req_wdata[8*p +: 8] = wbyte(seed, p);
    @(negedge clk);
    req_valid = 1'b0;
    e_off = a; e_rem = n; beats = 0; done_seen = 1'b0; err_seen = 1'b0; waitc = 0;
    while (!done_seen && waitc < 300) begin
      if (err) err_seen = 1'b1;
      if (bus_start) begin
        int mv;
        int d;
        beats++;
        check(int'(bus_addr) == e_off, {tg, " addr"}, 64'(bus_addr), 64'(e_off));
        check(int'(bus_size) == e_rem, {tg, " size"}, 64'(bus_size), 64'(e_rem));
        mv = w - (e_off % w);
        if (mv > e_rem) mv = e_rem;
        if (wr) begin
          exp_l = '0;
          for (int k = 3; k >= 0; k--) begin
            int cw;
            cw = 8 >> k;
            for (int p = e_off; p < e_off + e_rem; p++)
              if (p / cw == e_off / cw) exp_l[8*(p % cw) +: 8] = wbyte(seed, p);
          end
          check(bus_wdata == exp_l && bus_write, "R5 write lanes", bus_wdata, exp_l);
        end
        d = 1 + ((seed + beats) % 3);
        for (int j = 0; j < d; j++) begin
          @(negedge clk);
          if (err) err_seen = 1'b1;
          if (j == 0 && junk) begin
            req_valid = 1'b1; req_size = 4'b0001; req_addr = 3'd5;
          end
          if (j > 0) begin
            req_valid = 1'b0;
            check(!bus_start && int'(bus_addr) == e_off && int'(bus_size) == e_rem,
                  "R8 beat hold", {57'b0, bus_start, bus_addr, bus_size}, 64'(e_off * 16 + e_rem));
          end
          if (j == d - 1) begin
            bus_ack = 1'b1;
            for (int L = 0; L < 8; L++) bus_rdata[8*L +: 8] = 8'hE0 | 8'(L);
            for (int p = e_off; p < e_off + mv; p++) bus_rdata[8*(p % w) +: 8] = mbyte(seed, p);
          end
        end
        @(negedge clk);
        bus_ack = 1'b0; req_valid = 1'b0; bus_rdata = 64'hDEADBEEFCAFEF00D;
        e_off += mv; e_rem -= mv;
      end else if (xfer_done) begin
        done_seen = 1'b1;
      end else begin
        @(negedge clk);
        waitc++;
      end
    end
    check(done_seen, "R7 done", 64'(done_seen), 64'h1);
    check(beats == e_beats, {tg, " beat count"}, 64'(beats), 64'(e_beats));
    check(!err_seen, "R9 busy request ignored", 64'(err_seen), 64'h0);
    check(rd_valid == !wr, "R7 rd_valid", 64'(rd_valid), 64'(!wr));
    if (!wr) begin
      exp_rd = '0;
      for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = mbyte(seed, a + i);
      ok = (rd_data == exp_rd);
      check(ok, "R6 R7 read data", 64'(rd_data), 64'(exp_rd));
    end
    @(negedge clk);
    check(!xfer_done && !rd_valid && req_ready, "R7 pulse", {61'b0, xfer_done, rd_valid, req_ready}, 64'h1);
  endtask

  initial begin
    int seed;
    n_checks = 0; n_errors = 0; cyc = 0;
    rst_n = 1'b0; ext_en = 1'b1; port_sel = 2'd0; req_valid = 1'b0; req_write = 1'b0;
    req_size = 4'd0; req_addr = 3'd0; req_wdata = '0; bus_ack = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !bus_start && !err && !xfer_done && !rd_valid, "R9 reset state",
          {59'b0, req_ready, bus_start, err, xfer_done, rd_valid}, 64'h10);

    // Explicit 64-bit write pattern: 5 bytes at 011, lanes 0..3 = 3,3,0,3
    seed = 0;
    for (int pw = 0; pw < 4; pw++)
      for (int wr = 0; wr < 2; wr++)
        for (int n = 5; n <= 7; n++)
          for (int a = 0; a < 8; a++)
            if (is_legal(n, a)) begin
              seed++;
              run_xfer(pw, bit'(wr), n, a, seed);
            end

    // Illegal size/offset sweep (R1) and disabled mode (R2)
    for (int n = 0; n < 16; n++)
      for (int a = 0; a < 8; a++)
        if (!is_legal(n, a)) run_bad(1'b1, n, a, "R1 reject");
    for (int n = 5; n <= 7; n++)
      for (int a = 0; a < 8; a++)
        if (is_legal(n, a)) run_bad(1'b0, n, a, "R2 disabled");

    // Ack during the start cycle must not count (R8)
    @(negedge clk);
    port_sel = 2'd0; req_valid = 1'b1; req_write = 1'b0; req_size = 4'd6; req_addr = 3'd2;
    @(negedge clk);
    req_valid = 1'b0; bus_ack = 1'b1; bus_rdata = '0;
    @(negedge clk);
    bus_ack = 1'b0;
    check(!xfer_done && !req_ready, "R8 early ack ignored", {62'b0, xfer_done, req_ready}, 64'h0);
    @(negedge clk);
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    check(xfer_done, "R8 real ack", 64'(xfer_done), 64'h1);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule